// File: doc/BRIEF.md
# Command-Routed SPI FIFO Bridge

This block is an SPI slave that lets a host controller reach two internal byte queues: a transmit queue that the host fills, and a receive queue that the host empties. Each chip-select frame opens with a command byte. That byte decides where the rest of the frame goes. A write command sends every later MOSI byte into the transmit queue. A read command shifts receive-queue bytes out on MISO for as long as the host keeps clocking. No length field exists. The number of bytes moved is set only by how many SCLK cycles the host supplies.

On the other side, the block has a pop port for the transmit queue and a push port for the receive queue. These face the radio datapath. The block also reports the fill level of each queue, a full indication for the receive queue, and two sticky error flags. The SPI pins are asynchronous to the system clock. They pass through a synchronizer and are oversampled, so SCLK must run well below the system clock.

Top module: `hfifo_spi_bridge`

## Requirements
- R1: After reset both queues are empty, both levels read 0, `tx_empty` is 1, `rx_full` is 0, both error flags are 0, and `spi_miso` is 0.
- R2: The SPI timing is mode 0 (MOSI sampled on the SCLK rising edge, most significant bit first). The first byte after `spi_cs_n` falls is the command. The command value 0x66 appends every later complete byte of the frame to the transmit queue, in arrival order.
- R3: A complete byte written while the transmit queue holds `FIFO_DEPTH` bytes is dropped, and the queue contents stay unchanged. That write sets `tx_overflow`, which stays 1 until reset.
- R4: The command value 0x77 makes the block present receive-queue bytes on `spi_miso` in queue order, most significant bit first. Each bit changes after an SCLK falling edge. The first bit of each data byte is valid before that byte's first rising edge.
- R5: A receive byte leaves the queue only when the host supplies the first rising SCLK edge of that byte. A read frame that ends without data clocks leaves `rx_level` unchanged. Each started data byte lowers it by one.
- R6: A read data byte started while the receive queue is empty shifts out as 0x00 and sets `rx_underflow`, which stays 1 until reset.
- R7: Any other command value makes the block ignore the rest of the frame. `spi_miso` stays 0 and neither queue changes, even if later bytes equal 0x66 or 0x77.
- R8: Raising `spi_cs_n` ends the frame. An incomplete byte is discarded, and the next frame again starts with a command byte.
- R9: `tx_data` shows the oldest transmit byte without a pop (first-word fall-through). `tx_pop` removes that byte. A pop while `tx_empty` is 1 has no effect.
- R10: `rx_push` stores `rx_data` in the receive queue. A push while the queue holds `FIFO_DEPTH` bytes is dropped. `tx_level` and `rx_level` report the byte count, from 0 to `FIFO_DEPTH`, and `rx_full` is 1 exactly at `FIFO_DEPTH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock (asynchronous) |
| spi_cs_n | input | 1 | SPI chip select, active low (asynchronous) |
| spi_mosi | input | 1 | SPI data from the host |
| spi_miso | output | 1 | SPI data to the host |
| tx_pop | input | 1 | Remove the oldest transmit byte |
| tx_data | output | 8 | Oldest transmit byte (0 when empty) |
| tx_empty | output | 1 | Transmit queue holds no bytes |
| tx_level | output | LVL_W (7) | Transmit queue byte count |
| rx_push | input | 1 | Store `rx_data` into the receive queue |
| rx_data | input | 8 | Byte to store in the receive queue |
| rx_full | output | 1 | Receive queue holds `FIFO_DEPTH` bytes |
| rx_level | output | LVL_W (7) | Receive queue byte count |
| tx_overflow | output | 1 | Sticky: a host write found the transmit queue full |
| rx_underflow | output | 1 | Sticky: a host read found the receive queue empty |

## Verification
The bound checker watches, on every cycle, the invariants that hold between the command engine and the two queues:
- the engine never pushes into a full transmit queue;
- the engine never pops an empty receive queue;
- a queue level never exceeds the depth;
- a dropped radio push or an empty pop leaves the level where it was;
- both error flags, once set, stay set.

Only the bench's scenarios can show the rest:
- the byte order in and out of the queues;
- the bit timing on MISO relative to SCLK;
- command decoding, including ignored frames that contain valid command values;
- that a short byte at chip-select release is discarded;
- that read frames without data clocks consume nothing.

// File: rtl/hfifo_spi_pkg.sv
package hfifo_spi_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] CMD_TX_WRITE = 8'h66;
    localparam logic [BYTE_W-1:0] CMD_RX_READ  = 8'h77;

    typedef enum logic [1:0] {
        FRM_COMMAND = 2'd0,
        FRM_WRITE   = 2'd1,
        FRM_READ    = 2'd2,
        FRM_IGNORE  = 2'd3
    } frame_mode_e;

    typedef struct packed {
        frame_mode_e        mode;
        logic [2:0]         bitcnt;
        logic [BYTE_W-1:0]  shin;
        logic [BYTE_W-1:0]  shout;
        logic               miso;
        logic               loaded_empty;
        logic               tx_ovf;
        logic               rx_udf;
    } engine_state_t;

endpackage

// File: rtl/hfifo_pin_sync.sv
// Brings the asynchronous SPI pins into the clk domain and marks SCLK edges.
// STAGES must be at least 2.
module hfifo_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic cs_n_in,
    input  logic mosi_in,
    output logic cs_active,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic mosi_bit
);

    typedef struct packed {
        logic [STAGES:0]   sclk;
        logic [STAGES-1:0] cs_n;
        logic [STAGES-1:0] mosi;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.sclk = {sync_q.sclk[STAGES-1:0], sclk_in};
        sync_d.cs_n = {sync_q.cs_n[STAGES-2:0], cs_n_in};
        sync_d.mosi = {sync_q.mosi[STAGES-2:0], mosi_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q.sclk <= '0;
            sync_q.cs_n <= '1;
            sync_q.mosi <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign cs_active = ~sync_q.cs_n[STAGES-1];
    assign sclk_rise =  sync_q.sclk[STAGES-1] & ~sync_q.sclk[STAGES];
    assign sclk_fall = ~sync_q.sclk[STAGES-1] &  sync_q.sclk[STAGES];
    assign mosi_bit  =  sync_q.mosi[STAGES-1];

endmodule

// File: rtl/hfifo_byte_queue.sv
// Circular byte queue with first-word fall-through read data.
module hfifo_byte_queue #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 64,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             pop,
    output logic [WIDTH-1:0] rd_data,
    output logic             full,
    output logic             empty,
    output logic [LVL_W-1:0] level
);

    typedef struct packed {
        logic [AW-1:0]    wp;
        logic [AW-1:0]    rp;
        logic [LVL_W-1:0] cnt;
    } ptr_t;

    ptr_t ptr_d, ptr_q;
    logic [WIDTH-1:0] mem [DEPTH];
    logic push_ok, pop_ok;

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (ptr_q.cnt == LVL_W'(DEPTH));
    assign empty   = (ptr_q.cnt == '0);
    assign push_ok = push & ~full;
    assign pop_ok  = pop & ~empty;

    always_comb begin
        ptr_d = ptr_q;
        if (push_ok) ptr_d.wp = wrap_inc(ptr_q.wp);
        if (pop_ok)  ptr_d.rp = wrap_inc(ptr_q.rp);
        case ({push_ok, pop_ok})
            2'b10:   ptr_d.cnt = ptr_q.cnt + 1'b1;
            2'b01:   ptr_d.cnt = ptr_q.cnt - 1'b1;
            default: ptr_d.cnt = ptr_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[ptr_q.wp] <= wr_data;
    end

    assign rd_data = empty ? '0 : mem[ptr_q.rp];
    assign level   = ptr_q.cnt;

endmodule

// File: rtl/hfifo_cmd_engine.sv
// Frame decoder: command byte, write streaming, read shifting, error flags.
module hfifo_cmd_engine
    import hfifo_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_active,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              mosi_bit,
    input  logic              tx_full,
    input  logic              rx_empty,
    input  logic [BYTE_W-1:0] rx_head,
    output logic              tx_push,
    output logic [BYTE_W-1:0] tx_wdata,
    output logic              rx_pop,
    output logic              miso,
    output logic              tx_overflow,
    output logic              rx_underflow
);

    engine_state_t eng_d, eng_q;
    logic [BYTE_W-1:0] shin_next;

    assign shin_next = {eng_q.shin[BYTE_W-2:0], mosi_bit};

    always_comb begin
        eng_d    = eng_q;
        tx_push  = 1'b0;
        rx_pop   = 1'b0;
        tx_wdata = shin_next;

        if (!cs_active) begin
            // frame closed: drop partial byte, await a new command
            eng_d.mode         = FRM_COMMAND;
            eng_d.bitcnt       = '0;
            eng_d.shin         = '0;
            eng_d.shout        = '0;
            eng_d.miso         = 1'b0;
            eng_d.loaded_empty = 1'b0;
        end else begin
            if (sclk_rise) begin
                eng_d.shin   = shin_next;
                eng_d.bitcnt = eng_q.bitcnt + 1'b1;
                // first clock of a read byte commits the pop
                if (eng_q.mode == FRM_READ && eng_q.bitcnt == 3'd0) begin
                    if (eng_q.loaded_empty) eng_d.rx_udf = 1'b1;
                    else                    rx_pop       = 1'b1;
                end
                if (eng_q.bitcnt == 3'd7) begin
                    unique case (eng_q.mode)
                        FRM_COMMAND: begin
                            if (shin_next == CMD_TX_WRITE)     eng_d.mode = FRM_WRITE;
                            else if (shin_next == CMD_RX_READ) eng_d.mode = FRM_READ;
                            else                               eng_d.mode = FRM_IGNORE;
                        end
                        FRM_WRITE: begin
                            if (tx_full) eng_d.tx_ovf = 1'b1;
                            else         tx_push      = 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
            if (sclk_fall) begin
                if (eng_q.mode == FRM_READ) begin
                    if (eng_q.bitcnt == 3'd0) begin
                        // byte boundary: fetch the head without consuming it
                        eng_d.loaded_empty = rx_empty;
                        eng_d.miso         = ~rx_empty & rx_head[BYTE_W-1];
                        eng_d.shout        = rx_empty ? '0 : {rx_head[BYTE_W-2:0], 1'b0};
                    end else begin
                        eng_d.miso  = eng_q.shout[BYTE_W-1];
                        eng_d.shout = {eng_q.shout[BYTE_W-2:0], 1'b0};
                    end
                end else begin
                    eng_d.miso = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign miso         = eng_q.miso;
    assign tx_overflow  = eng_q.tx_ovf;
    assign rx_underflow = eng_q.rx_udf;

endmodule

// File: rtl/hfifo_spi_bridge.sv
module hfifo_spi_bridge
    import hfifo_spi_pkg::*;
#(
    parameter int FIFO_DEPTH  = 64,
    parameter int SYNC_STAGES = 2,
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic              tx_pop,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_empty,
    output logic [LVL_W-1:0]  tx_level,
    input  logic              rx_push,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_full,
    output logic [LVL_W-1:0]  rx_level,
    output logic              tx_overflow,
    output logic              rx_underflow
);

    logic              cs_active, sclk_rise, sclk_fall, mosi_bit;
    logic              tx_push_w, rx_pop_w, tx_full_w, rx_empty_w;
    logic [BYTE_W-1:0] tx_wdata_w, rx_head_w;

    hfifo_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_in   (spi_sclk),
        .cs_n_in   (spi_cs_n),
        .mosi_in   (spi_mosi),
        .cs_active (cs_active),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .mosi_bit  (mosi_bit)
    );

    hfifo_cmd_engine u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_active    (cs_active),
        .sclk_rise    (sclk_rise),
        .sclk_fall    (sclk_fall),
        .mosi_bit     (mosi_bit),
        .tx_full      (tx_full_w),
        .rx_empty     (rx_empty_w),
        .rx_head      (rx_head_w),
        .tx_push      (tx_push_w),
        .tx_wdata     (tx_wdata_w),
        .rx_pop       (rx_pop_w),
        .miso         (spi_miso),
        .tx_overflow  (tx_overflow),
        .rx_underflow (rx_underflow)
    );

    hfifo_byte_queue #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (tx_push_w),
        .wr_data (tx_wdata_w),
        .pop     (tx_pop),
        .rd_data (tx_data),
        .full    (tx_full_w),
        .empty   (tx_empty),
        .level   (tx_level)
    );

    hfifo_byte_queue #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (rx_push),
        .wr_data (rx_data),
        .pop     (rx_pop_w),
        .rd_data (rx_head_w),
        .full    (rx_full),
        .empty   (rx_empty_w),
        .level   (rx_level)
    );

endmodule

// File: rtl/hfifo_spi_checker.sv
module hfifo_spi_checker #(
    parameter int DEPTH = 64,
    parameter int LVL_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_push_w,
    input logic             tx_full_w,
    input logic             rx_pop_w,
    input logic             rx_empty_w,
    input logic             tx_pop,
    input logic [LVL_W-1:0] tx_level,
    input logic [LVL_W-1:0] rx_level,
    input logic             tx_overflow,
    input logic             rx_underflow
);

    a_r2_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push_w |-> !tx_full_w);

    a_r3_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        tx_overflow |=> tx_overflow);

    a_r3_overflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_overflow) |-> $past(tx_full_w));

    a_r5_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop_w |-> !rx_empty_w);

    a_r6_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rx_underflow |=> rx_underflow);

    a_r9_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level == '0 && !tx_push_w) |=> tx_level == '0);

    a_r10_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level == LVL_W'(DEPTH) && !rx_pop_w) |=> rx_level == LVL_W'(DEPTH));

    a_r10_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level <= LVL_W'(DEPTH)) && (rx_level <= LVL_W'(DEPTH)));

endmodule

bind hfifo_spi_bridge hfifo_spi_checker #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_push_w    (tx_push_w),
    .tx_full_w    (tx_full_w),
    .rx_pop_w     (rx_pop_w),
    .rx_empty_w   (rx_empty_w),
    .tx_pop       (tx_pop),
    .tx_level     (tx_level),
    .rx_level     (rx_level),
    .tx_overflow  (tx_overflow),
    .rx_underflow (rx_underflow)
);

// File: tb/sim_hfifo_spi_bridge.sv
`timescale 1ns/1ps
module sim_hfifo_spi_bridge;

    localparam int DEPTH = 64;
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam int HALF  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic spi_miso;
    logic tx_pop = 1'b0;
    logic [7:0] tx_data;
    logic tx_empty;
    logic [LVL_W-1:0] tx_level, rx_level;
    logic rx_push = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic rx_full, tx_overflow, rx_underflow;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    hfifo_spi_bridge #(.FIFO_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .tx_pop(tx_pop), .tx_data(tx_data), .tx_empty(tx_empty), .tx_level(tx_level),
        .rx_push(rx_push), .rx_data(rx_data), .rx_full(rx_full), .rx_level(rx_level),
        .tx_overflow(tx_overflow), .rx_underflow(rx_underflow)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic spi_begin();
        @(negedge clk) spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic spi_end();
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);
    endtask

    task automatic spi_bits(input int nbits, input logic [7:0] out_b, output logic [7:0] in_b);
        in_b = 8'h00;
        for (int i = 7; i > 7 - nbits; i--) begin
            @(negedge clk) spi_mosi = out_b[i];
            repeat (HALF) @(negedge clk);
            in_b[i] = spi_miso;
            spi_sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b0;
        end
    endtask

    task automatic spi_byte(input logic [7:0] out_b, output logic [7:0] in_b);
        spi_bits(8, out_b, in_b);
    endtask

    task automatic radio_push(input logic [7:0] b);
        @(negedge clk) begin rx_push = 1'b1; rx_data = b; end
        @(negedge clk) rx_push = 1'b0;
    endtask

    task automatic radio_pop();
        @(negedge clk) tx_pop = 1'b1;
        @(negedge clk) tx_pop = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 tx_level", 32'(tx_level), 0);
        check("R1 rx_level", 32'(rx_level), 0);
        check("R1 tx_empty", 32'(tx_empty), 1);
        check("R1 rx_full", 32'(rx_full), 0);
        check("R1 tx_overflow", 32'(tx_overflow), 0);
        check("R1 rx_underflow", 32'(rx_underflow), 0);
        check("R1 miso", 32'(spi_miso), 0);
    endtask

    task automatic t_tx_write();
        logic [7:0] r;
        spi_begin();
        spi_byte(8'h66, r);
        check("R2 miso zero in command", 32'(r), 0);
        spi_byte(8'hA5, r);
        spi_byte(8'h3C, r);
        spi_byte(8'h0F, r);
        spi_end();
        check("R2 tx_level after three", 32'(tx_level), 3);
        check("R9 tx_data head 1", 32'(tx_data), 32'hA5);
        radio_pop();
        check("R9 tx_data head 2", 32'(tx_data), 32'h3C);
        radio_pop();
        check("R2 tx_data head 3", 32'(tx_data), 32'h0F);
        radio_pop();
        check("R9 tx_empty after drain", 32'(tx_empty), 1);
        radio_pop();
        @(negedge clk);
        check("R9 pop on empty keeps level", 32'(tx_level), 0);
    endtask

    task automatic t_rx_read();
        logic [7:0] r;
        radio_push(8'h81);
        radio_push(8'h7E);
        radio_push(8'hC3);
        check("R10 rx_level after pushes", 32'(rx_level), 3);
        spi_begin();
        spi_byte(8'h77, r);
        spi_byte(8'h00, r);
        check("R4 first read byte", 32'(r), 32'h81);
        spi_byte(8'h00, r);
        check("R4 second read byte", 32'(r), 32'h7E);
        spi_end();
        check("R5 one byte left", 32'(rx_level), 1);
        // read frame with no data clocks consumes nothing
        spi_begin();
        spi_byte(8'h77, r);
        spi_end();
        check("R5 no clocks no pop", 32'(rx_level), 1);
        spi_begin();
        spi_byte(8'h77, r);
        spi_byte(8'hFF, r);
        spi_end();
        check("R4 third read byte", 32'(r), 32'hC3);
        check("R5 rx drained", 32'(rx_level), 0);
        check("R6 no underflow yet", 32'(rx_underflow), 0);
    endtask

    task automatic t_unknown_cmd();
        logic [7:0] r;
        logic [7:0] acc;
        acc = 8'h00;
        radio_push(8'h5A);
        spi_begin();
        spi_byte(8'h12, r); acc |= r;
        spi_byte(8'h66, r); acc |= r;
        spi_byte(8'h77, r); acc |= r;
        spi_byte(8'hFF, r); acc |= r;
        spi_end();
        check("R7 miso stays zero", 32'(acc), 0);
        check("R7 tx untouched", 32'(tx_level), 0);
        check("R7 rx untouched", 32'(rx_level), 1);
    endtask

    task automatic t_partial();
        logic [7:0] r;
        spi_begin();
        spi_byte(8'h66, r);
        spi_bits(5, 8'hF0, r);
        spi_end();
        check("R8 partial byte dropped", 32'(tx_level), 0);
        spi_begin();
        spi_byte(8'h66, r);
        spi_byte(8'h99, r);
        spi_end();
        check("R8 new frame count", 32'(tx_level), 1);
        check("R8 new frame data", 32'(tx_data), 32'h99);
        radio_pop();
        // leftover 0x5A from the ignored frame still readable
        spi_begin();
        spi_byte(8'h77, r);
        spi_byte(8'h00, r);
        spi_end();
        check("R8 read after ignored frame", 32'(r), 32'h5A);
    endtask

    task automatic t_underflow();
        logic [7:0] r;
        spi_begin();
        spi_byte(8'h77, r);
        spi_byte(8'h00, r);
        check("R6 empty read is zero", 32'(r), 0);
        spi_byte(8'h00, r);
        spi_end();
        check("R6 underflow set", 32'(rx_underflow), 1);
        check("R6 level stays zero", 32'(rx_level), 0);
        repeat (20) @(negedge clk);
        check("R6 underflow sticky", 32'(rx_underflow), 1);
    endtask

    task automatic t_overflow();
        logic [7:0] r;
        int bad;
        bad = 0;
        spi_begin();
        spi_byte(8'h66, r);
        for (int i = 0; i < DEPTH + 1; i++) spi_byte(8'(i + 1), r);
        spi_end();
        check("R3 tx_level at depth", 32'(tx_level), DEPTH);
        check("R3 overflow set", 32'(tx_overflow), 1);
        for (int i = 0; i < DEPTH; i++) begin
            if (tx_data !== 8'(i + 1)) bad++;
            radio_pop();
        end
        check("R3 stored bytes in order", 32'(bad), 0);
        check("R3 overflow sticky after drain", 32'(tx_overflow), 1);
    endtask

    task automatic t_rx_full();
        logic [7:0] r;
        for (int i = 0; i < DEPTH + 1; i++) radio_push(8'(8'h40 + i));
        check("R10 rx_level at depth", 32'(rx_level), DEPTH);
        check("R10 rx_full", 32'(rx_full), 1);
        spi_begin();
        spi_byte(8'h77, r);
        spi_byte(8'h00, r);
        spi_end();
        check("R10 oldest byte first", 32'(r), 32'h40);
        check("R10 rx_full cleared", 32'(rx_full), 0);
        check("R10 rx_level after one", 32'(rx_level), DEPTH - 1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_tx_write();
        t_rx_read();
        t_unknown_cmd();
        t_partial();
        t_underflow();
        t_overflow();
        t_rx_full();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule